// File: doc/BRIEF.md
# Masked BCD Calendar Alarm Comparator

This block watches a running calendar clock and raises an alarm when the time matches a programmed target. It holds six alarm bytes, one for each of these calendar fields: seconds, minutes, hours, weekday, day of month and month. Each byte carries a BCD target in its low seven bits and a compare-enable in its top bit. A field whose enable is clear is a don't-care. The year never takes part in the match.

The surrounding counters provide the current BCD fields and a one-cycle strobe for each seconds update. On every strobe the block evaluates the match. When every enabled field agrees, and at least one field is enabled, it sets a sticky alarm flag. The interrupt output is that flag gated by an interrupt-enable bit. Software uses a byte-wide register port to program the alarm bytes, to set the enable and to clear the flag. Reads are combinational from the index.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset every alarm byte and the control byte (index 14) read 0x00, and `alarm_irq_o` is low.
- R2: Alarm bytes live at register indices 8 to 13, holding seconds, minutes, hours, weekday, day of month and month in that order. A write to one of them is read back unchanged from the same index.
- R3: An alarm byte whose bit 7 is 0 counts as a match whatever the current value of its field.
- R4: An alarm byte whose bit 7 is 1 matches only when its bits 6:0 equal the current BCD field (month coded 1 to 12). A single enabled field that mismatches blocks the alarm.
- R5: The match is evaluated only in a cycle where `tick_i` is high. Matching time with no strobe leaves the flag unchanged.
- R6: When all six enable bits are 0, no strobe ever sets the flag.
- R7: The alarm flag is control bit 0. A match sets it even when the interrupt enable (control bit 3) is 0.
- R8: `alarm_irq_o` is high exactly while both the flag and control bit 3 are 1. It stays high until software clears the flag or the enable.
- R9: Writing the control byte with bit 0 = 0 clears the flag. Writing bit 0 = 1 never sets it. Control bit 3 takes the written value.
- R10: If a flag-clearing write and a matching strobe fall in the same cycle, the flag ends set.
- R11: Indices other than 8 to 14 read 0x00 and ignore writes. Control bits other than 0 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| tick_i | input | 1 | One-cycle seconds-update strobe |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 7 | Current hours, BCD |
| wday_i | input | 7 | Current weekday, BCD |
| mday_i | input | 7 | Current day of month, BCD |
| mon_i | input | 7 | Current month, BCD 1 to 12 |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is a software flag clear that lands in the same clock as a matching seconds strobe. In normal use the strobe comes once per second, so the two events almost never line up. The bench drives the strobe directly instead of waiting for it. It asserts the flag-clearing control write and a fully matching strobe on the same negative edge. It then reads the control byte to confirm that the new alarm was kept. The bench also covers match-without-strobe and mismatch-in-one-field by holding matching time values on the inputs for several cycles before and after the strobe.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int ALARM_BASE = 8;
  localparam int CTRL_IDX   = 14;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;
  localparam int EN_BIT     = BYTE_W - 1;
  localparam int VAL_W      = BYTE_W - 1;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int VAL_W = 7
) (
  input  logic [VAL_W:0]   cfg_i,
  input  logic [VAL_W-1:0] cur_i,
  output logic             hit_o,
  output logic             armed_o
);
  assign armed_o = cfg_i[VAL_W];
  // disabled field is a don't-care
  assign hit_o   = !cfg_i[VAL_W] || (cfg_i[VAL_W-1:0] == cur_i);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int N      = NUM_FIELDS,
  parameter int AW     = ADDR_W,
  parameter int DW     = BYTE_W,
  parameter int BASE   = ALARM_BASE,
  parameter int CTRL   = CTRL_IDX
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 flag_i,
  input  logic                 ie_i,
  output logic [N-1:0][DW-1:0] alarm_o,
  output logic                 ctrl_we_o,
  output logic [DW-1:0]        rdata_o
);
  assign ctrl_we_o = we_i && (addr_i == AW'(CTRL));

  for (genvar k = 0; k < N; k++) begin : g_fld
    localparam logic [AW-1:0] IDX = AW'(BASE + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     alarm_o[k] <= '0;
      else if (we_i && addr_i == IDX)  alarm_o[k] <= wdata_i;
    end

    assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == IDX) |=> (alarm_o[k] == $past(wdata_i)));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CTRL)) begin
      rdata_o[FLAG_BIT] = flag_i;
      rdata_o[IE_BIT]   = ie_i;
    end else begin
      for (int k = 0; k < N; k++)
        if (addr_i == AW'(BASE + k)) rdata_o = alarm_o[k];
    end
  end
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          flag_o,
  output logic          ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      ie_o   <= 1'b0;
    end else begin
      if (ctrl_we_i) ie_o <= wdata_i[IE_BIT];
      // new event wins over a concurrent clear
      if (set_i)                                  flag_o <= 1'b1;
      else if (ctrl_we_i && !wdata_i[FLAG_BIT])   flag_o <= 1'b0;
    end
  end

  assert_no_spont_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> !$rose(flag_o));
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[FLAG_BIT] && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  localparam int VW = DW - 1,
  localparam int N  = NUM_FIELDS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          tick_i,
  input  logic [VW-1:0] sec_i,
  input  logic [VW-1:0] min_i,
  input  logic [VW-1:0] hour_i,
  input  logic [VW-1:0] wday_i,
  input  logic [VW-1:0] mday_i,
  input  logic [VW-1:0] mon_i,
  output logic          alarm_irq_o
);
  logic [N-1:0][DW-1:0] alarm_q;
  logic [N-1:0][VW-1:0] cur_t;
  logic [N-1:0]         hit, armed;
  logic                 ctrl_we, flag_q, ie_q, set_ev;

  assign cur_t = {mon_i, mday_i, wday_i, hour_i, min_i, sec_i};

  alarm_regs #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag_q), .ie_i(ie_q),
    .alarm_o(alarm_q), .ctrl_we_o(ctrl_we), .rdata_o(reg_rdata_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_cmp
    alarm_field_cmp #(.VAL_W(VW)) u_cmp (
      .cfg_i(alarm_q[k]), .cur_i(cur_t[k]),
      .hit_o(hit[k]), .armed_o(armed[k])
    );
  end

  assign set_ev = tick_i && (&hit) && (|armed);

  alarm_flag_ctrl #(.DW(DW)) u_flag (
    .clk_i, .rst_ni,
    .set_i(set_ev), .ctrl_we_i(ctrl_we), .wdata_i(reg_wdata_i),
    .flag_o(flag_q), .ie_o(ie_q)
  );

  assign alarm_irq_o = flag_q && ie_q;

  assert_all_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && alarm_q[0][DW-1] == 1'b0 && alarm_q[1][DW-1] == 1'b0 &&
     alarm_q[2][DW-1] == 1'b0 && alarm_q[3][DW-1] == 1'b0 &&
     alarm_q[4][DW-1] == 1'b0 && alarm_q[5][DW-1] == 1'b0) |=> !$rose(flag_q));
  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_irq_o && !reg_we_i) |=> alarm_irq_o);
  assert_irq_needs_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reg_we_i) |=> !$rose(alarm_irq_o));
endmodule

// File: tb/tb_rtc_alarm_cmp.sv
`timescale 1ns/1ps
module tb_rtc_alarm_cmp;
  logic       clk = 0, rst_n = 0;
  logic       we = 0, tick = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [6:0] sec = 0, mn = 0, hr = 0, wd = 0, md = 0, mo = 0;
  logic       irq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  rtc_alarm_cmp dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_i(tick),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .wday_i(wd), .mday_i(md), .mon_i(mo),
    .alarm_irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_time(logic [6:0] s, m, h, w, dd, mm);
    sec = s; mn = m; hr = h; wd = w; md = dd; mo = mm;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 8; i <= 14; i++) begin
      rd(4'(i), d); chk("R1 reg after reset", d, 8'h00);
    end
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h81 + 8'(i * 16));
    for (int i = 0; i < 6; i++) begin
      rd(4'(8 + i), d); chk("R2 alarm readback", d, 8'h81 + 8'(i * 16));
    end
    wr(4'd3, 8'h5A); rd(4'd3, d); chk("R11 unmapped low", d, 8'h00);
    wr(4'd15, 8'hA5); rd(4'd15, d); chk("R11 unmapped high", d, 8'h00);
    wr(4'd14, 8'hFF); rd(4'd14, d); chk("R9 R11 write 1 no set", d, 8'h08);
    wr(4'd14, 8'h00);
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h00);
  endtask

  task automatic t_all_off();
    logic [7:0] d;
    set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00); pulse();
    set_time(7'h59, 7'h12, 7'h07, 7'h03, 7'h15, 7'h06); pulse();
    rd(4'd14, d); chk("R6 no enables no flag", d, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr(4'd14, 8'h08);
    wr(4'd8, 8'hB0);
    set_time(7'h31, 7'h44, 7'h09, 7'h02, 7'h21, 7'h05); pulse();
    rd(4'd14, d); chk("R4 sec mismatch", d, 8'h08);
    set_time(7'h30, 7'h44, 7'h09, 7'h02, 7'h21, 7'h05);
    repeat (3) @(negedge clk);
    rd(4'd14, d); chk("R5 match without strobe", d, 8'h08);
    chk("R5 irq low without strobe", {7'b0, irq}, 8'h00);
    pulse();
    rd(4'd14, d); chk("R3 other fields dont care", d, 8'h09);
    set_time(7'h31, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
    repeat (4) @(negedge clk);
    chk("R8 irq held", {7'b0, irq}, 8'h01);
    wr(4'd14, 8'h08);
    rd(4'd14, d); chk("R9 clear flag", d, 8'h08);
    chk("R8 irq drops on clear", {7'b0, irq}, 8'h00);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_multi();
    logic [7:0] d;
    wr(4'd14, 8'h00);
    wr(4'd10, 8'hA3); wr(4'd11, 8'h85); wr(4'd12, 8'hB1); wr(4'd13, 8'h92);
    set_time(7'h00, 7'h00, 7'h23, 7'h05, 7'h31, 7'h11); pulse();
    rd(4'd14, d); chk("R4 month mismatch", d, 8'h00);
    set_time(7'h00, 7'h00, 7'h23, 7'h04, 7'h31, 7'h12); pulse();
    rd(4'd14, d); chk("R4 weekday mismatch", d, 8'h00);
    set_time(7'h17, 7'h29, 7'h23, 7'h05, 7'h31, 7'h12); pulse();
    rd(4'd14, d); chk("R7 flag with ie off", d, 8'h01);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    wr(4'd14, 8'h09);
    chk("R8 irq unmasked", {7'b0, irq}, 8'h01);
    wr(4'd14, 8'h01);
    chk("R8 irq off by ie", {7'b0, irq}, 8'h00);
    rd(4'd14, d); chk("R9 flag kept with bit0 1", d, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    @(negedge clk); we = 1; addr = 4'd14; wdata = 8'h08; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rd(4'd14, d); chk("R10 set beats clear", d, 8'h09);
    chk("R10 irq after collide", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_all_off();
    t_single();
    t_multi();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule